// File: doc/BRIEF.md
# Digit-Serial Decimal Arithmetic Unit

This block does arithmetic on 25-digit decimal numbers, one BCD digit per clock. It holds one internal 25-digit working register (register 0). The working register is a recirculating shift register, and its least significant digit sits at the head. The other six register addresses (1 to 6) live in external storage. Their digits arrive on the 4-bit X bus. Every result digit leaves on the 4-bit Y bus so that the external storage can take it.

A 12-bit micro-instruction arrives one bit per clock on a single serial pin, least significant bit first, during the 12 cycles just before a sync pulse. The sync pulse latches the instruction. The 25 cycles after the sync cycle form one pass: the unit handles digit 0 (the least significant) in the first of those cycles and digit 24 in the last. When the pass ends, the unit registers a borrow output and a flag output. Both hold until the next sync pulse, which clears them.

Top module: `bcd_serial_unit`

## Requirements
- R1: The micro-instruction is the 12 bits sampled in the 12 cycles before the sync cycle, least significant bit first. Its fields are: source address in bits 2:0, destination address in bits 5:3, opcode in bits 9:6. Bits 11:10 are ignored.
- R2: A pass lasts exactly the 25 cycles after the sync cycle, least significant digit first. In pass cycle k the Y bus carries result digit k. Outside a pass the Y bus is 0. The working register shifts only during a pass.
- R3: Address 0 reads the working register's head digit. Any other address reads the X bus. The working register takes the result only when the destination is 0. Otherwise it recirculates unchanged.
- R4: Opcode 1 computes destination plus source with decimal carry correction. At the end of the pass, the flag equals the final carry and the borrow output is 0.
- R5: Opcode 2 computes destination minus source with decimal borrow correction. At the end of the pass, both the flag and the borrow output equal the final borrow.
- R6: Opcode 3 adds one to the destination, and the flag equals the final carry. Opcode 4 subtracts one from the destination, and both the flag and the borrow output equal the final borrow.
- R7: Opcode 5 writes the ten's complement of the destination (zero minus destination). The flag and the borrow output are set exactly when the destination was nonzero.
- R8: Opcode 0 copies the source to the destination. Opcode 6 writes zero. Opcode 7 writes the source field value (0 to 7) into digit 0 and zero into the other digits. All three leave both the flag and the borrow output at 0.
- R9: Opcode 8 compares the destination with the source and leaves the destination unchanged. The borrow output is set when the destination is less than the source. The flag is set when the two are equal.
- R10: The sync pulse clears the flag and the borrow output. They are updated once at the end of the pass and then hold. Opcodes 9 to 15 leave the destination unchanged and both outputs at 0.
- R11: After reset, the working register is zero, the Y bus is 0, and the flag and the borrow output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Digit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | One-cycle frame start; latches the instruction and starts a pass |
| uins_i | input | 1 | Serial micro-instruction bit |
| xbus_i | input | 4 | Digit from external register storage |
| ybus_o | output | 4 | Result digit during a pass, 0 otherwise |
| borrow_o | output | 1 | Final borrow of the last pass |
| flag_o | output | 1 | Carry, borrow or equality status of the last pass |

## Verification
The assertions check on every cycle the rules that hold at any moment. The digit counter stays in range, and a pass is exactly 25 digits long. The latched instruction and the working register move only when they should. Every result digit is valid BCD. The flag and the borrow output change only at a sync pulse or at the end of a pass. Only the bench's scenarios can show that the whole 25-digit values are right. That covers carries across all 25 digits and overflow past the top digit, borrow chains, the ten's complement of zero and of all nines, and compare results. It also covers whether a value written into the working register comes back intact when a later pass reads it.

// File: rtl/bcd_su_pkg.sv
package bcd_su_pkg;
  localparam int DIGW   = 4;
  localparam int ADRW   = 3;
  localparam int OPW    = 4;
  localparam int UINS_W = 12;
  localparam int FIELD_W = 2 * ADRW + OPW;

  typedef enum logic [OPW-1:0] {
    OP_MOVE = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_INC  = 4'd3,
    OP_DEC  = 4'd4,
    OP_CMPL = 4'd5,
    OP_CLR  = 4'd6,
    OP_LDI  = 4'd7,
    OP_CMP  = 4'd8
  } op_e;

  typedef struct packed {
    op_e             op;
    logic [ADRW-1:0] dst;
    logic [ADRW-1:0] src;
  } uins_t;

  // returns {carry, digit}
  function automatic logic [DIGW:0] bcd_add(input logic [DIGW-1:0] a,
                                            input logic [DIGW-1:0] b,
                                            input logic ci);
    logic [DIGW:0] s;
    s = {1'b0, a} + {1'b0, b} + {{DIGW{1'b0}}, ci};
    if (s > 5'd9) bcd_add = {1'b1, s[DIGW-1:0] + 4'd6};
    else          bcd_add = {1'b0, s[DIGW-1:0]};
  endfunction

  // returns {borrow, digit}
  function automatic logic [DIGW:0] bcd_sub(input logic [DIGW-1:0] a,
                                            input logic [DIGW-1:0] b,
                                            input logic bi);
    logic [DIGW:0] d;
    d = {1'b0, a} - {1'b0, b} - {{DIGW{1'b0}}, bi};
    if (d[DIGW]) bcd_sub = {1'b1, d[DIGW-1:0] - 4'd6};
    else         bcd_sub = {1'b0, d[DIGW-1:0]};
  endfunction
endpackage

// File: rtl/bcd_frame_ctl.sv
module bcd_frame_ctl #(
  parameter int NDIG = 25,
  localparam int CW = $clog2(NDIG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  output logic          active_o,
  output logic          first_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;
  logic          active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (sync_i) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (cnt_q == CW'(NDIG - 1)) begin
        cnt_q    <= '0;
        active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign first_o  = active_q && (cnt_q == '0);
  assign last_o   = active_q && (cnt_q == CW'(NDIG - 1));

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q < CW'(NDIG))); // R2
  AST_PASS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> ($past(cnt_q) == CW'(NDIG - 1))); // R2
  AST_SYNC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |-> !active_q); // R2
endmodule

// File: rtl/bcd_uins_rx.sv
module bcd_uins_rx
  import bcd_su_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sync_i,
  input  logic  bit_i,
  output uins_t dec_o
);
  logic [UINS_W-1:0] shreg_q;
  uins_t             dec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      dec_q   <= uins_t'('0);
    end else begin
      shreg_q <= {bit_i, shreg_q[UINS_W-1:1]};
      if (sync_i) dec_q <= uins_t'(shreg_q[FIELD_W-1:0]);
    end
  end

  assign dec_o = dec_q;

  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |=> $stable(dec_q)); // R1
endmodule

// File: rtl/bcd_areg.sv
module bcd_areg
  import bcd_su_pkg::*;
#(
  parameter int NDIG = 25
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_i,
  input  logic            wr_i,
  input  logic [DIGW-1:0] res_i,
  output logic [DIGW-1:0] head_o
);
  logic [DIGW-1:0] dig_q [NDIG];
  logic [DIGW-1:0] din;

  assign din = wr_i ? res_i : dig_q[0];

  generate
    for (genvar i = 0; i < NDIG; i++) begin : g_dig
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dig_q[i] <= '0;
        else if (shift_i) dig_q[i] <= (i == NDIG - 1) ? din : dig_q[(i + 1) % NDIG];
      end
    end
  endgenerate

  assign head_o = dig_q[0];

  AST_A_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_i |=> $stable(head_o)); // R2
endmodule

// File: rtl/bcd_digit_alu.sv
module bcd_digit_alu
  import bcd_su_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            fire_i,
  input  logic            first_i,
  input  logic            last_i,
  input  uins_t           ins_i,
  input  logic [DIGW-1:0] a_i,
  input  logic [DIGW-1:0] x_i,
  output logic [DIGW-1:0] res_o,
  output logic            wr_a_o,
  output logic            borrow_o,
  output logic            flag_o
);
  logic            cy_q, zacc_q, borrow_q, flag_q;
  logic [DIGW-1:0] src_d, dst_d, unit_d;
  logic [DIGW:0]   alu;
  logic            co, nz, sub_kind, arith_kind, cmp_kind;

  assign src_d  = (ins_i.src == '0) ? a_i : x_i;
  assign dst_d  = (ins_i.dst == '0) ? a_i : x_i;
  assign unit_d = first_i ? DIGW'(1) : '0;

  always_comb begin
    alu = '0;
    res_o = dst_d;
    co = 1'b0;
    nz = 1'b0;
    unique case (ins_i.op)
      OP_MOVE: res_o = src_d;
      OP_ADD:  begin alu = bcd_add(dst_d, src_d, cy_q);  res_o = alu[DIGW-1:0]; co = alu[DIGW]; end
      OP_SUB:  begin alu = bcd_sub(dst_d, src_d, cy_q);  res_o = alu[DIGW-1:0]; co = alu[DIGW]; end
      OP_INC:  begin alu = bcd_add(dst_d, unit_d, cy_q); res_o = alu[DIGW-1:0]; co = alu[DIGW]; end
      OP_DEC:  begin alu = bcd_sub(dst_d, unit_d, cy_q); res_o = alu[DIGW-1:0]; co = alu[DIGW]; end
      OP_CMPL: begin alu = bcd_sub('0, dst_d, cy_q);     res_o = alu[DIGW-1:0]; co = alu[DIGW]; end
      OP_CLR:  res_o = '0;
      OP_LDI:  res_o = first_i ? {1'b0, ins_i.src} : '0;
      OP_CMP:  begin
        alu = bcd_sub(dst_d, src_d, cy_q);
        co  = alu[DIGW];
        nz  = (alu[DIGW-1:0] != '0);
      end
      default: res_o = dst_d;
    endcase
  end

  assign sub_kind   = (ins_i.op == OP_SUB) || (ins_i.op == OP_DEC) ||
                      (ins_i.op == OP_CMPL) || (ins_i.op == OP_CMP);
  assign arith_kind = (ins_i.op == OP_ADD) || (ins_i.op == OP_INC) ||
                      (ins_i.op == OP_SUB) || (ins_i.op == OP_DEC) || (ins_i.op == OP_CMPL);
  assign cmp_kind   = (ins_i.op == OP_CMP);
  assign wr_a_o     = fire_i && (ins_i.dst == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cy_q <= 1'b0; zacc_q <= 1'b0; borrow_q <= 1'b0; flag_q <= 1'b0;
    end else if (clr_i) begin
      cy_q <= 1'b0; zacc_q <= 1'b0; borrow_q <= 1'b0; flag_q <= 1'b0;
    end else if (fire_i) begin
      cy_q   <= co;
      zacc_q <= zacc_q | nz;
      if (last_i) begin
        borrow_q <= sub_kind & co;
        flag_q   <= cmp_kind ? ~(zacc_q | nz) : (arith_kind & co);
      end
    end
  end

  assign borrow_o = borrow_q;
  assign flag_o   = flag_q;

  AST_DIGIT_BCD: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && x_i <= 4'd9 && a_i <= 4'd9) |-> (res_o <= 4'd9)); // R4
  AST_ADD_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && last_i && ins_i.op == OP_ADD) |=> !borrow_o); // R4
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !(fire_i && last_i)) |=> ($stable(flag_o) && $stable(borrow_o))); // R10
  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!flag_o && !borrow_o)); // R10
endmodule

// File: rtl/bcd_serial_unit.sv
module bcd_serial_unit
  import bcd_su_pkg::*;
#(
  parameter int NDIG = 25
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync_i,
  input  logic            uins_i,
  input  logic [DIGW-1:0] xbus_i,
  output logic [DIGW-1:0] ybus_o,
  output logic            borrow_o,
  output logic            flag_o
);
  logic            active, first, last, wr_a;
  uins_t           dec;
  logic [DIGW-1:0] a_head, res;

  bcd_frame_ctl #(.NDIG(NDIG)) u_frame (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i),
    .active_o(active), .first_o(first), .last_o(last)
  );

  bcd_uins_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .bit_i(uins_i), .dec_o(dec)
  );

  bcd_areg #(.NDIG(NDIG)) u_areg (
    .clk(clk), .rst_n(rst_n), .shift_i(active), .wr_i(wr_a),
    .res_i(res), .head_o(a_head)
  );

  bcd_digit_alu u_alu (
    .clk(clk), .rst_n(rst_n), .clr_i(sync_i), .fire_i(active),
    .first_i(first), .last_i(last), .ins_i(dec), .a_i(a_head), .x_i(xbus_i),
    .res_o(res), .wr_a_o(wr_a), .borrow_o(borrow_o), .flag_o(flag_o)
  );

  assign ybus_o = active ? res : '0;
endmodule

// File: tb/sim_bcd_serial_unit.sv
module sim_bcd_serial_unit;
  localparam int ND = 25;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0, sync_i = 1'b0, uins_i = 1'b0;
  logic [3:0] x_i = '0;
  wire  [3:0] y_o;
  wire        borrow_o, flag_o;

  int n_cmp = 0, n_bad = 0;
  int model_a[ND];
  int expq[$];
  string tagq[$];
  logic mon_en = 1'b0;

  bcd_serial_unit #(.NDIG(ND)) u0 (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .uins_i(uins_i),
    .xbus_i(x_i), .ybus_o(y_o), .borrow_o(borrow_o), .flag_o(flag_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // monitor: pops the scoreboard one digit per pass cycle
  always @(negedge clk) begin : mon
    int e;
    string t;
    #1;
    if (mon_en) begin
      if (expq.size() == 0) begin
        chk("R2 unexpected digit", 1, 0);
      end else begin
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(t, int'(y_o), e);
      end
    end
  end

  task automatic run_op(input int op, input int src, input int dst, input int rsv,
                        input int xd[ND], input string tag);
    int y[ND];
    int c, t, dd, sd, nz, ef, eb;
    logic [11:0] w;
    w = {rsv[1:0], op[3:0], dst[2:0], src[2:0]};
    c = 0; nz = 0;
    for (int k = 0; k < ND; k++) begin
      dd = (dst == 0) ? model_a[k] : xd[k];
      sd = (src == 0) ? model_a[k] : xd[k];
      case (op)
        0: y[k] = sd;
        1: begin t = dd + sd + c; y[k] = t % 10; c = t / 10; end
        2: begin t = dd - sd - c; c = (t < 0); y[k] = (t + 10) % 10; end
        3: begin t = dd + (k == 0) + c; y[k] = t % 10; c = t / 10; end
        4: begin t = dd - (k == 0) - c; c = (t < 0); y[k] = (t + 10) % 10; end
        5: begin t = 0 - dd - c; c = (t < 0); y[k] = (t + 10) % 10; end
        6: y[k] = 0;
        7: y[k] = (k == 0) ? src : 0;
        8: begin t = dd - sd - c; c = (t < 0); if ((t + 10) % 10 != 0) nz = 1; y[k] = dd; end
        default: y[k] = dd;
      endcase
    end
    ef = 0; eb = 0;
    if (op == 1 || op == 3) ef = c;
    if (op == 2 || op == 4 || op == 5) begin ef = c; eb = c; end
    if (op == 8) begin eb = c; ef = (nz == 0); end

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      uins_i = w[i]; // R1 serial, LSB first
    end
    @(negedge clk);
    uins_i = 1'b0;
    sync_i = 1'b1;
    for (int k = 0; k < ND; k++) begin
      @(negedge clk);
      sync_i = 1'b0;
      x_i = 4'(xd[k]);
      expq.push_back(y[k]);
      tagq.push_back($sformatf("%s digit %0d", tag, k));
      mon_en = 1'b1;
      if (k == 0) chk({tag, " R10 flags cleared at sync"}, int'({flag_o, borrow_o}), 0);
    end
    @(negedge clk);
    mon_en = 1'b0;
    x_i = '0;
    chk({tag, " flag"}, int'(flag_o), ef);
    chk({tag, " borrow"}, int'(borrow_o), eb);
    repeat (3) @(negedge clk);
    chk({tag, " R10 flag held"}, int'(flag_o), ef);
    chk({tag, " R10 borrow held"}, int'(borrow_o), eb);
    chk({tag, " R2 idle Y"}, int'(y_o), 0);
    if (dst == 0) for (int k = 0; k < ND; k++) model_a[k] = y[k];
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin : drv
    int z[ND], nines[ND], pat[ND], pat2[ND], big[ND];
    for (int k = 0; k < ND; k++) begin
      model_a[k] = 0;
      z[k] = 0;
      nines[k] = 9;
      pat[k] = (k * 7 + 3) % 10;
      pat2[k] = (k * 3 + 8) % 10;
      big[k] = pat[k];
    end
    big[ND-1] = 9; pat[ND-1] = 4;

    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 Y at reset", int'(y_o), 0);
    chk("R11 flag at reset", int'(flag_o), 0);
    chk("R11 borrow at reset", int'(borrow_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(0, 0, 1, 0, z, "R11 A zero after reset");    // read A out through Y

    run_op(7, 5, 0, 3, z, "R8 R1 load immediate");       // reserved bits set, ignored
    run_op(1, 1, 0, 0, nines, "R4 add overflow");        // 5 + all nines
    run_op(2, 2, 0, 0, pat2, "R5 subtract");
    run_op(4, 0, 0, 0, z, "R6 decrement");
    run_op(6, 0, 0, 0, z, "R8 clear");
    run_op(4, 0, 0, 0, z, "R6 decrement of zero");
    run_op(3, 0, 0, 0, z, "R6 increment of all nines");
    run_op(4, 0, 0, 0, z, "R6 decrement to nines");
    run_op(5, 0, 0, 0, z, "R7 complement of nines");
    run_op(6, 0, 0, 0, z, "R8 clear again");
    run_op(5, 0, 0, 0, z, "R7 complement of zero");
    run_op(0, 1, 0, 0, pat, "R8 transfer X to A");
    run_op(8, 1, 0, 0, pat, "R9 compare equal");
    run_op(8, 1, 0, 0, big, "R9 compare less");
    run_op(8, 3, 0, 0, pat2, "R9 compare greater");
    run_op(1, 0, 2, 0, pat2, "R3 add into external");   // A must stay
    run_op(0, 0, 4, 0, z, "R3 A unchanged readback");
    run_op(12, 1, 0, 0, nines, "R10 unused opcode");
    run_op(0, 0, 1, 0, z, "R10 unused opcode readback");
    run_op(2, 0, 0, 0, z, "R5 self subtract");
    finish_run();
  end
endmodule